// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from host memory to a MAC-side byte stream. Software builds a ring of descriptors in memory. Each descriptor is sixteen bytes long: a status word, a control word, a buffer address and one unused word. Software hands a descriptor to the engine by setting its own bit, then wakes the engine by writing to the poll register. The engine walks the ring for as long as the descriptor at its pointer is owned. For each owned descriptor it reads the buffer word by word and streams the bytes out with start and end markers. It then writes a completion status back into the descriptor, which also returns ownership to software.

A descriptor can be marked as a setup descriptor. Its buffer does not go to the wire. The words are written instead into an address-filter table, indexed by word number. When the engine meets a descriptor it does not own, it parks in a suspended state until the next poll write. A separate enable bit stops the engine. Setting that bit again restarts the engine at the ring base.

Top module: `tx_desc_dma`

## Requirements
- R1: After reset, proc_state reads 0, and mem_req, tx_valid and filt_we are all low.
- R2: Setting bit 13 of the mode register (offset 0x30) starts fetching at the ring base. The ring base register is at offset 0x20, and its low 4 bits are ignored. Clearing bit 13 drives a suspended engine to proc_state 0. While stopped, a poll write leaves memory and the byte stream untouched.
- R3: If a fetched status word has bit 31 (own) clear, the engine writes nothing and goes to proc_state 6. A write of any value to offset 0x08 makes it fetch that same descriptor again. A poll write while that descriptor is still unowned changes nothing in memory and sends no bytes.
- R4: Descriptors follow one another at a 16-byte stride. Word 0 is status, word 1 is control and word 2 is the buffer address, which is word aligned. The engine processes consecutive owned descriptors in one pass, without a further poll.
- R5: In the control word, bit 30 marks last segment, bit 29 first segment, bit 27 setup and bit 25 end of ring, and bits 10:0 hold the byte count. Buffer byte n leaves as tx_data taken from bits 8*(n%4)+7 down to 8*(n%4) of buffer word n/4.
- R6: tx_sof is high on the first byte of a first-segment descriptor. tx_eof is high on the last byte of a last-segment descriptor. Neither marker is high on any other byte.
- R7: A descriptor with a byte count of zero completes and is written back without sending any byte.
- R8: The descriptor after an end-of-ring descriptor is read from the ring base.
- R9: Completion writes back status bit 31 clear. The written status is 0 on success. Bit 15 is set if tx_err was high on any accepted byte of that descriptor.
- R10: A setup descriptor sends no bytes. It writes buffer word k to filt_addr k, suppressing indices at or beyond FILT_WORDS, and writes back a status of 0x7FFFFFFF.
- R11: While tx_valid is high and tx_ready is low, tx_data, tx_sof and tx_eof hold steady, and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access complete; read data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Byte value |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_err | input | 1 | MAC reports a failure on the accepted byte |
| filt_we | output | 1 | Filter table write |
| filt_addr | output | FILT_AW | Filter table word index |
| filt_data | output | 32 | Filter table word |
| proc_state | output | 3 | Engine state: 0 stopped, 1 fetch, 3 read, 5 setup, 6 suspended, 7 close |

## Verification
The bench builds the engine with ADDR_W=10, which lets a 256-word memory model hold both the four-slot ring and a 512-byte buffer area. It keeps LEN_W=11 and FILT_WORDS=48, so a 192-byte setup descriptor fills the filter table exactly, to its last index. Seven table vectors fill the four slots and wrap back to slot 0. The vectors cover lengths that end on every byte lane, the zero count and a stalling MAC.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam int OWN_BIT  = 31;
    localparam int LS_BIT   = 30;
    localparam int FS_BIT   = 29;
    localparam int SET_BIT  = 27;
    localparam int EOR_BIT  = 25;
    localparam int ES_BIT   = 15;
    localparam int TXEN_BIT = 13;

    localparam logic [31:0] SETUP_DONE_WORD = 32'h7FFF_FFFF;

    localparam logic [7:0] OFS_POLL = 8'h08;
    localparam logic [7:0] OFS_BASE = 8'h20;
    localparam logic [7:0] OFS_MODE = 8'h30;

    typedef enum logic [3:0] {
        SQ_STOP, SQ_SUSP, SQ_RD_STAT, SQ_RD_CTL, SQ_RD_BUF,
        SQ_RD_WORD, SQ_PUSH, SQ_FILT, SQ_WB, SQ_ADV
    } sq_state_e;

    typedef enum logic [2:0] {
        PS_STOPPED   = 3'd0,
        PS_FETCH     = 3'd1,
        PS_READ      = 3'd3,
        PS_SETUP     = 3'd5,
        PS_SUSPENDED = 3'd6,
        PS_CLOSE     = 3'd7
    } pstate_e;

    typedef struct packed {
        logic last;
        logic first;
        logic setup;
        logic eor;
    } ctl_flags_t;

    function automatic ctl_flags_t decode_flags(input logic [31:0] w);
        ctl_flags_t f;
        f.last  = w[LS_BIT];
        f.first = w[FS_BIT];
        f.setup = w[SET_BIT];
        f.eor   = w[EOR_BIT];
        return f;
    endfunction

    function automatic pstate_e state_code(input sq_state_e s, input logic setup);
        case (s)
            SQ_STOP:                        return PS_STOPPED;
            SQ_SUSP:                        return PS_SUSPENDED;
            SQ_RD_STAT, SQ_RD_CTL, SQ_RD_BUF: return PS_FETCH;
            SQ_RD_WORD, SQ_PUSH:            return setup ? PS_SETUP : PS_READ;
            SQ_FILT:                        return PS_SETUP;
            default:                        return PS_CLOSE;
        endcase
    endfunction

endpackage

// File: rtl/tdr_csr.sv
module tdr_csr
    import tdr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [ADDR_W-1:0] ring_base,
    output logic              tx_en,
    output logic              poll_pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_base  <= '0;
            tx_en      <= 1'b0;
            poll_pulse <= 1'b0;
        end else begin
            poll_pulse <= reg_we && (reg_addr == OFS_POLL);
            if (reg_we && reg_addr == OFS_BASE)
                ring_base <= {reg_wdata[ADDR_W-1:4], 4'b0000};
            if (reg_we && reg_addr == OFS_MODE)
                tx_en <= reg_wdata[TXEN_BIT];
        end
    end

    // R2
    base_align_chk: assert property (@(posedge clk) disable iff (rst)
        ring_base[3:0] == 4'b0000);

endmodule

// File: rtl/tdr_unpack.sv
module tdr_unpack (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] word,
    input  logic [2:0]  nbytes,
    input  logic        sof_in,
    input  logic        eof_in,
    output logic        busy,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_sof,
    output logic        out_eof,
    input  logic        out_ready
);

    logic [31:0] word_q;
    logic [2:0]  cnt_q;
    logic [1:0]  lane_q;
    logic        sof_q;
    logic        eof_q;

    assign busy      = (cnt_q != 3'd0);
    assign out_valid = busy;
    assign out_data  = word_q[8*lane_q +: 8];
    assign out_sof   = sof_q && busy;
    assign out_eof   = eof_q && (cnt_q == 3'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            cnt_q  <= '0;
            lane_q <= '0;
            sof_q  <= 1'b0;
            eof_q  <= 1'b0;
        end else if (load && !busy) begin
            word_q <= word;
            cnt_q  <= nbytes;
            lane_q <= 2'd0;
            sof_q  <= sof_in;
            eof_q  <= eof_in;
        end else if (busy && out_ready) begin
            cnt_q  <= cnt_q - 3'd1;
            lane_q <= lane_q + 2'd1;
            sof_q  <= 1'b0;
        end
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_sof) && $stable(out_eof));

    // R6
    marker_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (out_sof || out_eof) |-> out_valid);

endmodule

// File: rtl/tdr_sequencer.sv
module tdr_sequencer
    import tdr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 11,
    parameter int FILT_WORDS = 48,
    localparam int FILT_AW   = $clog2(FILT_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  ring_base,
    input  logic               tx_en,
    input  logic               poll,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    output logic               unp_load,
    output logic [31:0]        unp_word,
    output logic [2:0]         unp_nbytes,
    output logic               unp_sof,
    output logic               unp_eof,
    input  logic               unp_busy,
    input  logic               byte_err,
    output logic               filt_we,
    output logic [FILT_AW-1:0] filt_addr,
    output logic [31:0]        filt_data,
    output logic [2:0]         proc_state
);

    localparam int OFF_W = LEN_W + 1;

    sq_state_e         st_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] buf_q;
    ctl_flags_t        flags_q;
    logic [LEN_W-1:0]  len_q;
    logic [OFF_W-1:0]  off_q;
    logic [31:0]       word_q;
    logic              err_q;

    logic [OFF_W:0]    off_plus4;
    logic              last_word;
    logic [OFF_W-1:0]  rem;
    logic [OFF_W-1:0]  word_idx;

    assign off_plus4 = {1'b0, off_q} + (OFF_W+1)'(4);
    assign last_word = off_plus4 >= (OFF_W+1)'(len_q);
    assign rem       = OFF_W'(len_q) - off_q;
    assign word_idx  = off_q >> 2;

    assign unp_word   = word_q;
    assign unp_nbytes = last_word ? rem[2:0] : 3'd4;
    assign unp_sof    = flags_q.first && (off_q == '0);
    assign unp_eof    = flags_q.last && last_word;
    assign filt_addr  = FILT_AW'(word_idx);
    assign filt_data  = word_q;
    assign proc_state = state_code(st_q, flags_q.setup);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = '0;
        unp_load  = 1'b0;
        filt_we   = 1'b0;
        case (st_q)
            SQ_RD_STAT: mem_req = 1'b1;
            SQ_RD_CTL: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + ADDR_W'(4);
            end
            SQ_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + ADDR_W'(8);
            end
            SQ_RD_WORD: begin
                mem_req  = 1'b1;
                mem_addr = buf_q + ADDR_W'(off_q);
            end
            SQ_PUSH: unp_load = !unp_busy;
            SQ_FILT: filt_we = (int'(word_idx) < FILT_WORDS);
            SQ_WB: begin
                mem_req   = !unp_busy;
                mem_we    = 1'b1;
                mem_wdata = flags_q.setup ? SETUP_DONE_WORD
                          : (err_q ? (32'd1 << ES_BIT) : 32'd0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_STOP;
            ptr_q   <= '0;
            buf_q   <= '0;
            flags_q <= '0;
            len_q   <= '0;
            off_q   <= '0;
            word_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            if (byte_err) err_q <= 1'b1;
            case (st_q)
                SQ_STOP: if (tx_en) begin
                    ptr_q <= ring_base;
                    st_q  <= SQ_RD_STAT;
                end
                SQ_SUSP: begin
                    if (!tx_en)    st_q <= SQ_STOP;
                    else if (poll) st_q <= SQ_RD_STAT;
                end
                SQ_RD_STAT: if (mem_ack) begin
                    err_q <= 1'b0;
                    st_q  <= mem_rdata[OWN_BIT] ? SQ_RD_CTL : SQ_SUSP;
                end
                SQ_RD_CTL: if (mem_ack) begin
                    flags_q <= decode_flags(mem_rdata);
                    len_q   <= mem_rdata[LEN_W-1:0];
                    st_q    <= SQ_RD_BUF;
                end
                SQ_RD_BUF: if (mem_ack) begin
                    buf_q <= {mem_rdata[ADDR_W-1:2], 2'b00};
                    off_q <= '0;
                    st_q  <= (len_q == '0) ? SQ_WB : SQ_RD_WORD;
                end
                SQ_RD_WORD: if (mem_ack) begin
                    word_q <= mem_rdata;
                    st_q   <= flags_q.setup ? SQ_FILT : SQ_PUSH;
                end
                SQ_PUSH: if (!unp_busy) begin
                    off_q <= off_plus4[OFF_W-1:0];
                    st_q  <= last_word ? SQ_WB : SQ_RD_WORD;
                end
                SQ_FILT: begin
                    off_q <= off_plus4[OFF_W-1:0];
                    st_q  <= last_word ? SQ_WB : SQ_RD_WORD;
                end
                SQ_WB: if (mem_ack) st_q <= SQ_ADV;
                SQ_ADV: begin
                    ptr_q <= flags_q.eor ? ring_base : ptr_q + ADDR_W'(16);
                    st_q  <= tx_en ? SQ_RD_STAT : SQ_STOP;
                end
                default: st_q <= SQ_STOP;
            endcase
        end
    end

    // R9
    wb_own_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !mem_wdata[OWN_BIT]);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R10
    setup_off_wire_chk: assert property (@(posedge clk) disable iff (rst)
        filt_we |-> !unp_busy);

    // R3
    susp_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        proc_state == PS_SUSPENDED |-> !mem_req);

endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma
    import tdr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 11,
    parameter int FILT_WORDS = 48,
    localparam int FILT_AW   = $clog2(FILT_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic               tx_sof,
    output logic               tx_eof,
    input  logic               tx_ready,
    input  logic               tx_err,
    output logic               filt_we,
    output logic [FILT_AW-1:0] filt_addr,
    output logic [31:0]        filt_data,
    output logic [2:0]         proc_state
);

    logic [ADDR_W-1:0] ring_base;
    logic              tx_en;
    logic              poll;
    logic              unp_load;
    logic [31:0]       unp_word;
    logic [2:0]        unp_nbytes;
    logic              unp_sof;
    logic              unp_eof;
    logic              unp_busy;
    logic              byte_err;

    assign byte_err = tx_err && tx_valid && tx_ready;

    tdr_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .ring_base  (ring_base),
        .tx_en      (tx_en),
        .poll_pulse (poll)
    );

    tdr_sequencer #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .FILT_WORDS (FILT_WORDS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ring_base  (ring_base),
        .tx_en      (tx_en),
        .poll       (poll),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .unp_load   (unp_load),
        .unp_word   (unp_word),
        .unp_nbytes (unp_nbytes),
        .unp_sof    (unp_sof),
        .unp_eof    (unp_eof),
        .unp_busy   (unp_busy),
        .byte_err   (byte_err),
        .filt_we    (filt_we),
        .filt_addr  (filt_addr),
        .filt_data  (filt_data),
        .proc_state (proc_state)
    );

    tdr_unpack u_unpack (
        .clk       (clk),
        .rst       (rst),
        .load      (unp_load),
        .word      (unp_word),
        .nbytes    (unp_nbytes),
        .sof_in    (unp_sof),
        .eof_in    (unp_eof),
        .busy      (unp_busy),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_sof   (tx_sof),
        .out_eof   (tx_eof),
        .out_ready (tx_ready)
    );

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mem_req && !tx_valid && !filt_we);

endmodule

// File: tb/tx_desc_dma_test.sv
module tx_desc_dma_test;

    localparam int AW   = 10;
    localparam int FW   = 48;
    localparam int FAW  = $clog2(FW);
    localparam int RING = 32'h100;
    localparam int BUFA = 32'h200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic          mem_ack = 1'b0;
    logic          tx_valid, tx_sof, tx_eof;
    logic [7:0]    tx_data;
    logic          tx_ready;
    logic          tx_err = 1'b0;
    logic          filt_we;
    logic [FAW-1:0] filt_addr;
    logic [31:0]   filt_data;
    logic [2:0]    proc_state;

    tx_desc_dma #(.ADDR_W(AW), .LEN_W(11), .FILT_WORDS(FW)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .tx_ready(tx_ready), .tx_err(tx_err),
        .filt_we(filt_we), .filt_addr(filt_addr), .filt_data(filt_data),
        .proc_state(proc_state)
    );

    // memory model: 256 words, one wait cycle per access
    logic [31:0] mem [0:255];
    logic [7:0]  lat = '0;
    logic        hw_en = 1'b0;
    logic [7:0]  hw_addr = '0;
    logic [31:0] hw_data = '0;
    assign mem_rdata = mem[lat];

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                lat     <= mem_addr[9:2];
            end
            if (mem_ack && mem_we) mem[lat] <= mem_wdata;
            if (hw_en) mem[hw_addr] <= hw_data;
        end
    end

    // stall pattern
    logic bp = 1'b0;
    logic [7:0] cyc = '0;
    always @(posedge clk) cyc <= cyc + 8'd1;
    assign tx_ready = bp ? (cyc[0] ^ cyc[2]) : 1'b1;

    // capture of the byte stream and filter writes
    logic [7:0]  cap_d [0:1023];
    logic        cap_s [0:1023];
    logic        cap_e [0:1023];
    int          cap_n;
    logic [31:0] fcap_d [0:127];
    int          fcap_a [0:127];
    int          fcap_n;

    always @(posedge clk) begin
        if (rst) cap_n <= 0;
        else if (tx_valid && tx_ready) begin
            cap_d[cap_n] <= tx_data;
            cap_s[cap_n] <= tx_sof;
            cap_e[cap_n] <= tx_eof;
            cap_n <= cap_n + 1;
        end
    end

    always @(posedge clk) begin
        if (rst) fcap_n <= 0;
        else if (filt_we) begin
            fcap_d[fcap_n] <= filt_data;
            fcap_a[fcap_n] <= int'(filt_addr);
            fcap_n <= fcap_n + 1;
        end
    end

    int total = 0;
    int bad   = 0;
    int cur_slot = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic mem_wr(input int byte_addr, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = 8'(byte_addr >> 2); hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int seed, input int j);
        return 8'(seed * 7 + j * 3 + 1);
    endfunction

    task automatic fill_buf(input int seed, input int n);
        for (int k = 0; k < (n + 3) / 4; k++)
            mem_wr(BUFA + 4 * k, {pat(seed, 4*k+3), pat(seed, 4*k+2),
                                  pat(seed, 4*k+1), pat(seed, 4*k)});
    endtask

    function automatic logic [31:0] ctl_word(input int slot, input int len,
                                             input bit fs, input bit ls, input bit st);
        return (32'(ls) << 30) | (32'(fs) << 29) | (32'(st) << 27)
             | ((slot == 3) ? (32'd1 << 25) : 32'd0) | 32'(len);
    endfunction

    task automatic put_desc(input int slot, input int len, input bit fs,
                            input bit ls, input bit st);
        int a;
        a = RING + 16 * slot;
        mem_wr(a + 4, ctl_word(slot, len, fs, ls, st));
        mem_wr(a + 8, BUFA);
        mem_wr(a, 32'h8000_0000);
    endtask

    task automatic wait_done(input int slot, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!mem[(RING + 16 * slot) >> 2][31]) begin
                ok = 1'b1;
                break;
            end
        end
        repeat (12) @(negedge clk);
    endtask

    // run one descriptor and check everything it should produce
    task automatic run_one(input string req, input int len, input bit fs,
                           input bit ls, input bit st, input int seed,
                           input logic [31:0] exp_stat);
        int c0, f0, nb, nf, mism, sofs, eofs;
        bit ok, sof_ok, eof_ok;
        fill_buf(seed, len);
        put_desc(cur_slot, len, fs, ls, st);
        c0 = cap_n; f0 = fcap_n;
        reg_wr(8'h08, 32'h1234_5678);
        wait_done(cur_slot, ok);
        chk(ok, req, "descriptor released", ok, 1);
        nb = st ? 0 : len;
        chk(cap_n - c0 == nb, req, "byte count", cap_n - c0, nb);
        mism = 0; sofs = 0; eofs = 0; sof_ok = 1; eof_ok = 1;
        for (int j = 0; j < cap_n - c0; j++) begin
            if (cap_d[c0 + j] !== pat(seed, j)) mism++;
            if (cap_s[c0 + j]) begin sofs++; if (j != 0) sof_ok = 0; end
            if (cap_e[c0 + j]) begin eofs++; if (j != nb - 1) eof_ok = 0; end
        end
        chk(mism == 0, "R5", "byte order mismatches", mism, 0);
        chk(sof_ok && sofs == int'(fs && nb > 0), "R6", "sof markers", sofs, int'(fs && nb > 0));
        chk(eof_ok && eofs == int'(ls && nb > 0), "R6", "eof markers", eofs, int'(ls && nb > 0));
        chk(mem[(RING + 16 * cur_slot) >> 2] == exp_stat, "R9", "status write-back",
            mem[(RING + 16 * cur_slot) >> 2], exp_stat);
        nf = st ? (len + 3) / 4 : 0;
        if (nf > FW) nf = FW;
        chk(fcap_n - f0 == nf, "R10", "filter writes", fcap_n - f0, nf);
        chk(proc_state == 3'd6, "R3", "suspended after ring empty", proc_state, 6);
        cur_slot = (cur_slot + 1) % 4;
    endtask

    // vector table: [14] stall, [13] last, [12] first, [10:0] length
    localparam int NV = 7;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 1'b0, 11'd1},
        {1'b1, 1'b1, 1'b1, 1'b0, 11'd4},
        {1'b1, 1'b1, 1'b1, 1'b0, 11'd13},
        {1'b0, 1'b0, 1'b1, 1'b0, 11'd6},
        {1'b0, 1'b1, 1'b0, 1'b0, 11'd7},
        {1'b0, 1'b1, 1'b1, 1'b0, 11'd0},
        {1'b1, 1'b1, 1'b1, 1'b0, 11'd30}
    };

    initial begin
        repeat (2) @(posedge clk);
        // watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0, f0, mism, sofs, eofs;
        bit ok;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(proc_state == 3'd0, "R1", "state in reset", proc_state, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !tx_valid && !filt_we, "R1", "outputs idle after reset",
            {mem_req, tx_valid, filt_we}, 0);
        chk(proc_state == 3'd0, "R1", "stopped after reset", proc_state, 0);

        // R2 base with low bits set, then enable; empty ring suspends (R3)
        reg_wr(8'h20, RING | 32'h7);
        reg_wr(8'h30, 32'h0000_2000);
        repeat (10) @(negedge clk);
        chk(proc_state == 3'd6, "R3", "suspend on unowned slot 0", proc_state, 6);
        chk(mem[RING >> 2] == 32'h0, "R3", "no write to unowned status", mem[RING >> 2], 0);

        // R3 poll with nothing owned
        c0 = cap_n;
        reg_wr(8'h08, 32'h0);
        repeat (12) @(negedge clk);
        chk(mem[RING >> 2] == 32'h0 && cap_n == c0, "R3", "idle poll changes nothing",
            cap_n - c0, 0);

        // table walk: covers R5 R6 R7 R8 R11 and ring wrap
        for (int v = 0; v < NV; v++) begin
            bp = VEC[v][14];
            run_one((v >= 4) ? "R8" : (VEC[v][10:0] == 0 ? "R7" : "R11"),
                    int'(VEC[v][10:0]), VEC[v][12], VEC[v][13], 1'b0, v + 3, 32'h0);
        end
        bp = 1'b0;

        // R9 error summary
        tx_err = 1'b1;
        run_one("R9", 5, 1'b1, 1'b1, 1'b0, 21, 32'h0000_8000);
        tx_err = 1'b0;

        // R10 setup descriptor of 192 bytes
        f0 = fcap_n;
        run_one("R10", 192, 1'b0, 1'b0, 1'b1, 40, 32'h7FFF_FFFF);
        mism = 0;
        for (int k = 0; k < 48; k++) begin
            if (fcap_a[f0 + k] != k) mism++;
            if (fcap_d[f0 + k] !== {pat(40, 4*k+3), pat(40, 4*k+2),
                                     pat(40, 4*k+1), pat(40, 4*k)}) mism++;
        end
        chk(mism == 0, "R10", "filter contents", mism, 0);

        // R4 two owned descriptors, one poll
        fill_buf(50, 8);
        put_desc((cur_slot + 1) % 4, 2, 1'b0, 1'b1, 1'b0);
        put_desc(cur_slot, 3, 1'b1, 1'b0, 1'b0);
        c0 = cap_n;
        reg_wr(8'h08, 32'h1);
        wait_done((cur_slot + 1) % 4, ok);
        chk(ok && cap_n - c0 == 5, "R4", "chained pass byte count", cap_n - c0, 5);
        mism = 0; sofs = 0; eofs = 0;
        for (int j = 0; j < 5; j++) begin
            if (cap_d[c0 + j] !== pat(50, (j < 3) ? j : j - 3)) mism++;
            if (cap_s[c0 + j]) sofs += (j == 0) ? 1 : 10;
            if (cap_e[c0 + j]) eofs += (j == 4) ? 1 : 10;
        end
        chk(mism == 0 && sofs == 1 && eofs == 1, "R4", "chained pass data and markers",
            mism * 100 + sofs * 10 + eofs, 11);
        cur_slot = (cur_slot + 2) % 4;

        // R2 disable, poll ignored, re-enable restarts at base
        reg_wr(8'h30, 32'h0);
        repeat (4) @(negedge clk);
        chk(proc_state == 3'd0, "R2", "stopped after disable", proc_state, 0);
        fill_buf(60, 4);
        put_desc(0, 4, 1'b1, 1'b1, 1'b0);
        c0 = cap_n;
        reg_wr(8'h08, 32'h1);
        repeat (20) @(negedge clk);
        chk(mem[RING >> 2][31] && cap_n == c0, "R2", "poll ignored while stopped",
            mem[RING >> 2], 32'h8000_0000);
        cur_slot = 0;
        reg_wr(8'h30, 32'h0000_2000);
        wait_done(0, ok);
        chk(ok && cap_n - c0 == 4 && mem[RING >> 2] == 32'h0, "R2",
            "restart at ring base", cap_n - c0, 4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule